// File: doc/BRIEF.md
# Boost Frequency Controller

This block sits beside an activity monitor and turns its sustained-crossing events into a frequency request. It keeps a boost term. A sustained-high event raises the boost geometrically and adds a fixed step. A sustained-low event shrinks the boost geometrically until it drops to zero. After every update the block also recomputes the monitor's raw and averaged watermarks from the current frequency, the maximum frequency and the sampling period. It also re-arms the enables for the two sustained-crossing directions.

Events are latched into pending flags. A single shared restoring divider handles every division by 100, by 1000 and by the period, so each update takes a few hundred cycles. While an update runs, `busy_o` is high. Events that arrive during that time stay pending and are serviced afterwards. A start pulse re-seeds the block: it clears the boost, and the average becomes the current frequency times the period.

Top module: `boost_ctrl`

## Requirements
- R1: A high event sets boost to min(boost*200/100, 2^32-1) + 16000 and sets the low-direction enable. The boost output changes only in the cycle `done_o` is high.
- R2: If the raised boost is greater than or equal to `max_freq_i`, boost becomes `max_freq_i` and the high-direction enable is cleared. At least one of the two enables is always high.
- R3: A low event sets boost to boost*50/100 and sets the high-direction enable.
- R4: If the lowered boost is below 8000, boost becomes 0 and the low-direction enable is cleared.
- R5: When both events are pending, only the high rule is applied. Both pending flags are then cleared, so the low event is dropped.
- R6: Every percent product saturates to 2^32-1. The target sum also saturates to 2^32-1.
- R7: The band is ((max*6/1000) mod 2^32) * period mod 2^32. The average upper watermark is min(avg, 2^32-1-band)+band. The average lower watermark is max(avg, band)-band. The lower value never exceeds the upper value.
- R8: Let v = cur*period mod 2^32. The raw upper watermark is v*60/100 and the raw lower watermark is v*40/100.
- R9: The target is min((avg/period)*166/100, 2^32-1) + boost, where boost is the new boost value.
- R10: A start pulse clears boost, sets the high enable, clears the low enable and uses avg = cur*period mod 2^32 for all watermarks and the target. Start takes precedence over pending events and discards them.
- R11: An event that arrives while `busy_o` is high is held and serviced after the current update ends.
- R12: `done_o` is a single-cycle pulse in the first cycle after `busy_o` falls, and `busy_o` is low whenever `done_o` is high.
- R13: After reset, boost, target and all watermarks are 0, the high enable is 1, the low enable is 0, and `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Re-seed pulse |
| up_evt_i | input | 1 | Sustained-high event pulse |
| dn_evt_i | input | 1 | Sustained-low event pulse |
| avg_count_i | input | 32 | Averaged activity count |
| cur_freq_i | input | 32 | Current frequency |
| max_freq_i | input | 32 | Maximum frequency |
| period_i | input | 9 | Sampling period, at least 1 |
| busy_o | output | 1 | Update in progress |
| done_o | output | 1 | Update complete pulse |
| boost_o | output | 32 | Boost term |
| target_o | output | 32 | Requested frequency |
| raw_upper_o | output | 32 | Raw upper watermark |
| raw_lower_o | output | 32 | Raw lower watermark |
| avg_upper_o | output | 32 | Average upper watermark |
| avg_lower_o | output | 32 | Average lower watermark |
| up_en_o | output | 1 | High-direction enable |
| dn_en_o | output | 1 | Low-direction enable |

## Verification
The bench drives a chain of high events until the boost hits the ceiling and separates the additive-step path from the clamp path. A chain of low events then takes the boost down to the floor and separates plain geometric decay from the zeroing path. Two further patterns cover the watermark arithmetic. One uses an average near the top of the range, which exposes upper-watermark saturation and target saturation. The other uses an average smaller than the band, which exposes the lower-watermark floor. Simultaneous events, an event during an update and a start pulse between events distinguish the priority, hold and discard behaviours.

// File: rtl/boost_pkg.sv
package boost_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_BOOST, ST_BANDF, ST_RAWUP, ST_RAWLO, ST_AVGQ, ST_TGT
  } step_e;
endpackage

// File: rtl/div_seq.sv
module div_seq #(
  parameter int W = 48
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic [W-1:0] quot_o,
  output logic         done_o
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem_q, quo_q, dvs_q;
  logic [CW-1:0] cnt_q;
  logic          run_q, done_q;
  logic [W:0]    shifted;
  logic          fits;

  assign shifted = {rem_q, quo_q[W-1]};
  assign fits    = shifted >= {1'b0, dvs_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0; quo_q <= '0; dvs_q <= '0;
      cnt_q <= '0; run_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !run_q) begin
        rem_q <= '0;
        quo_q <= dividend_i;
        dvs_q <= divisor_i;
        cnt_q <= CW'(W);
        run_q <= 1'b1;
      end else if (run_q) begin
        if (fits) rem_q <= W'(shifted - {1'b0, dvs_q});
        else      rem_q <= shifted[W-1:0];
        quo_q <= {quo_q[W-2:0], fits};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign quot_o = quo_q;
  assign done_o = done_q;
endmodule

// File: rtl/boost_rule.sv
module boost_rule #(
  parameter int FW   = 32,
  parameter int STEP = 16000
) (
  input  logic          is_up_i,
  input  logic [FW-1:0] pct_i,
  input  logic [FW-1:0] max_i,
  input  logic          up_en_i,
  input  logic          dn_en_i,
  output logic [FW-1:0] boost_o,
  output logic          up_en_o,
  output logic          dn_en_o
);
  logic [FW:0] raised;
  assign raised = {1'b0, pct_i} + (FW+1)'(STEP);

  always_comb begin
    boost_o = pct_i;
    up_en_o = up_en_i;
    dn_en_o = dn_en_i;
    if (is_up_i) begin
      dn_en_o = 1'b1;
      if (raised >= {1'b0, max_i}) begin
        boost_o = max_i;
        up_en_o = 1'b0;
      end else begin
        boost_o = raised[FW-1:0];
      end
    end else begin
      up_en_o = 1'b1;
      if (pct_i < FW'(STEP / 2)) begin
        boost_o = '0;
        dn_en_o = 1'b0;
      end
    end
  end
endmodule

// File: rtl/wmark_calc.sv
module wmark_calc #(
  parameter int FW = 32
) (
  input  logic [FW-1:0] avg_i,
  input  logic [FW-1:0] band_i,
  output logic [FW-1:0] upper_o,
  output logic [FW-1:0] lower_o
);
  logic [FW-1:0] head;
  assign head    = ~band_i;
  assign upper_o = ((avg_i < head) ? avg_i : head) + band_i;
  assign lower_o = ((avg_i > band_i) ? avg_i : band_i) - band_i;
endmodule

// File: rtl/boost_ctrl.sv
module boost_ctrl
  import boost_pkg::*;
#(
  parameter int FW       = 32,
  parameter int PW       = 9,
  parameter int UP_COEFF = 200,
  parameter int DN_COEFF = 50,
  parameter int UP_THR   = 60,
  parameter int DN_THR   = 40,
  parameter int STEP     = 16000,
  parameter int BAND_PM  = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          up_evt_i,
  input  logic          dn_evt_i,
  input  logic [FW-1:0] avg_count_i,
  input  logic [FW-1:0] cur_freq_i,
  input  logic [FW-1:0] max_freq_i,
  input  logic [PW-1:0] period_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [FW-1:0] boost_o,
  output logic [FW-1:0] target_o,
  output logic [FW-1:0] raw_upper_o,
  output logic [FW-1:0] raw_lower_o,
  output logic [FW-1:0] avg_upper_o,
  output logic [FW-1:0] avg_lower_o,
  output logic          up_en_o,
  output logic          dn_en_o
);
  localparam int DW   = FW + 16;
  localparam int SUST = 10000 / UP_THR;

  step_e         step_q;
  logic          issued_q, is_up_q, done_q;
  logic          st_pend_q, up_pend_q, dn_pend_q;
  logic [FW-1:0] cur_q, max_q, avg_q, band_q, avgq_q;
  logic [PW-1:0] per_q;
  logic [FW-1:0] boost_nx, ru_nx, rl_nx;
  logic          ue_nx, de_nx;
  logic [FW-1:0] boost_r, target_r, ru_r, rl_r, au_r, al_r;
  logic          ue_r, de_r;

  logic [DW-1:0] dvd, dvs, quot;
  logic          div_start, div_done;
  logic [FW-1:0] q_sat, scaled, pct_boost, rule_boost, au_w, al_w;
  logic          rule_ue, rule_de;
  logic [FW:0]   tsum;
  logic [2*FW-1:0] cur_per, band_prod, seed_prod;
  logic          idle, take_start, take_evt;

  assign idle       = (step_q == ST_IDLE);
  assign take_start = idle && st_pend_q;
  assign take_evt   = idle && !st_pend_q && (up_pend_q || dn_pend_q);
  assign cur_per    = (2*FW)'(cur_q) * (2*FW)'(per_q);
  assign scaled     = cur_per[FW-1:0];
  assign band_prod  = (2*FW)'(quot[FW-1:0]) * (2*FW)'(per_q);
  assign seed_prod  = (2*FW)'(cur_freq_i) * (2*FW)'(period_i);
  assign q_sat      = (|quot[DW-1:FW]) ? '1 : quot[FW-1:0];
  assign pct_boost  = q_sat;
  assign tsum       = {1'b0, q_sat} + {1'b0, boost_nx};
  assign div_start  = !idle && !issued_q;

  always_comb begin
    dvd = '0;
    dvs = DW'(100);
    unique case (step_q)
      ST_BOOST: dvd = DW'(boost_r) * DW'(is_up_q ? UP_COEFF : DN_COEFF);
      ST_BANDF: begin dvd = DW'(max_q) * DW'(BAND_PM); dvs = DW'(1000); end
      ST_RAWUP: dvd = DW'(scaled) * DW'(UP_THR);
      ST_RAWLO: dvd = DW'(scaled) * DW'(DN_THR);
      ST_AVGQ:  begin dvd = DW'(avg_q); dvs = DW'(per_q); end
      ST_TGT:   dvd = DW'(avgq_q) * DW'(SUST);
      default:  dvd = '0;
    endcase
  end

  div_seq #(.W(DW)) u_div (
    .clk_i, .rst_ni, .start_i(div_start), .dividend_i(dvd), .divisor_i(dvs),
    .quot_o(quot), .done_o(div_done)
  );

  boost_rule #(.FW(FW), .STEP(STEP)) u_rule (
    .is_up_i(is_up_q), .pct_i(pct_boost), .max_i(max_q),
    .up_en_i(ue_nx), .dn_en_i(de_nx),
    .boost_o(rule_boost), .up_en_o(rule_ue), .dn_en_o(rule_de)
  );

  wmark_calc #(.FW(FW)) u_wm (
    .avg_i(avg_q), .band_i(band_q), .upper_o(au_w), .lower_o(al_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= ST_IDLE; issued_q <= 1'b0; is_up_q <= 1'b0; done_q <= 1'b0;
      st_pend_q <= 1'b0; up_pend_q <= 1'b0; dn_pend_q <= 1'b0;
      cur_q <= '0; max_q <= '0; avg_q <= '0; band_q <= '0; avgq_q <= '0;
      per_q <= '0; boost_nx <= '0; ru_nx <= '0; rl_nx <= '0;
      ue_nx <= 1'b1; de_nx <= 1'b0;
      boost_r <= '0; target_r <= '0; ru_r <= '0; rl_r <= '0;
      au_r <= '0; al_r <= '0; ue_r <= 1'b1; de_r <= 1'b0;
    end else begin
      done_q    <= 1'b0;
      // pulses landing in an accept cycle stay pending for the next update
      st_pend_q <= (st_pend_q && !take_start) || start_i;
      up_pend_q <= (up_pend_q && !take_start && !take_evt) || up_evt_i;
      dn_pend_q <= (dn_pend_q && !take_start && !take_evt) || dn_evt_i;
      if (div_start) issued_q <= 1'b1;

      if (take_start || take_evt) begin
        cur_q <= cur_freq_i;
        max_q <= max_freq_i;
        per_q <= period_i;
      end
      if (take_start) begin
        avg_q    <= seed_prod[FW-1:0];
        boost_nx <= '0;
        ue_nx    <= 1'b1;
        de_nx    <= 1'b0;
        step_q   <= ST_BANDF;
      end else if (take_evt) begin
        avg_q   <= avg_count_i;
        is_up_q <= up_pend_q;
        ue_nx   <= ue_r;
        de_nx   <= de_r;
        step_q  <= ST_BOOST;
      end

      if (div_done) begin
        issued_q <= 1'b0;
        unique case (step_q)
          ST_BOOST: begin
            boost_nx <= rule_boost; ue_nx <= rule_ue; de_nx <= rule_de;
            step_q <= ST_BANDF;
          end
          ST_BANDF: begin band_q <= band_prod[FW-1:0]; step_q <= ST_RAWUP; end
          ST_RAWUP: begin ru_nx <= q_sat; step_q <= ST_RAWLO; end
          ST_RAWLO: begin rl_nx <= q_sat; step_q <= ST_AVGQ; end
          ST_AVGQ:  begin avgq_q <= quot[FW-1:0]; step_q <= ST_TGT; end
          ST_TGT: begin
            target_r <= tsum[FW] ? '1 : tsum[FW-1:0];
            boost_r  <= boost_nx;
            ue_r     <= ue_nx;
            de_r     <= de_nx;
            ru_r     <= ru_nx;
            rl_r     <= rl_nx;
            au_r     <= au_w;
            al_r     <= al_w;
            done_q   <= 1'b1;
            step_q   <= ST_IDLE;
          end
          default: step_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign busy_o      = !idle;
  assign done_o      = done_q;
  assign boost_o     = boost_r;
  assign target_o    = target_r;
  assign raw_upper_o = ru_r;
  assign raw_lower_o = rl_r;
  assign avg_upper_o = au_r;
  assign avg_lower_o = al_r;
  assign up_en_o     = ue_r;
  assign dn_en_o     = de_r;
endmodule

// File: rtl/boost_ctrl_chk.sv
module boost_ctrl_chk #(
  parameter int FW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          done_o,
  input logic [FW-1:0] boost_o,
  input logic [FW-1:0] raw_upper_o,
  input logic [FW-1:0] raw_lower_o,
  input logic [FW-1:0] avg_upper_o,
  input logic [FW-1:0] avg_lower_o,
  input logic          up_en_o,
  input logic          dn_en_o
);
  assert_done_after_busy_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  assert_done_not_busy_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  assert_one_enable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_en_o || dn_en_o);
  assert_boost_held_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(boost_o));
  assert_avg_order_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    avg_lower_o <= avg_upper_o);
  assert_raw_order_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raw_lower_o <= raw_upper_o);
endmodule

bind boost_ctrl boost_ctrl_chk #(.FW(FW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .done_o(done_o),
  .boost_o(boost_o), .raw_upper_o(raw_upper_o), .raw_lower_o(raw_lower_o),
  .avg_upper_o(avg_upper_o), .avg_lower_o(avg_lower_o),
  .up_en_o(up_en_o), .dn_en_o(dn_en_o)
);

// File: tb/sim_boost_ctrl.sv
module sim_boost_ctrl;
  localparam longint unsigned MASK = 64'hFFFF_FFFF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, up_evt = 1'b0, dn_evt = 1'b0;
  logic [31:0] avg = '0, cur = '0, mx = '0;
  logic [8:0]  per = 9'd1;
  logic busy, done, ue, de;
  logic [31:0] boost, target, ru, rl, au, al;

  always #2.5 clk = ~clk;

  boost_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .up_evt_i(up_evt), .dn_evt_i(dn_evt),
    .avg_count_i(avg), .cur_freq_i(cur), .max_freq_i(mx), .period_i(per),
    .busy_o(busy), .done_o(done), .boost_o(boost), .target_o(target),
    .raw_upper_o(ru), .raw_lower_o(rl), .avg_upper_o(au), .avg_lower_o(al),
    .up_en_o(ue), .dn_en_o(de)
  );

  int n_chk = 0, n_bad = 0;
  longint unsigned m_b = 0;
  bit m_ue = 1'b1, m_de = 1'b0;
  longint unsigned e_t, e_ru, e_rl, e_au, e_al;
  bit f_clamp, f_floor, f_sat;

  task automatic check(string tag, longint unsigned got, longint unsigned exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  function automatic longint unsigned pct(longint unsigned v, longint unsigned c);
    longint unsigned r = v * c / 100;
    return (r > MASK) ? MASK : r;
  endfunction

  // kind: 0 start, 1 high, 2 low, 3 both
  task automatic model(int kind, longint unsigned a, longint unsigned c,
                       longint unsigned m, longint unsigned p);
    longint unsigned band, v, s, aa;
    f_clamp = 0; f_floor = 0; f_sat = 0;
    aa = a;
    if (kind == 0) begin
      aa = (c * p) & MASK; m_b = 0; m_ue = 1; m_de = 0;
    end else if (kind == 1 || kind == 3) begin
      s = pct(m_b, 200) + 16000; m_de = 1;
      if (s >= m) begin m_b = m; m_ue = 0; f_clamp = 1; end else m_b = s;
    end else begin
      s = pct(m_b, 50); m_ue = 1;
      if (s < 8000) begin m_b = 0; m_de = 0; f_floor = 1; end else m_b = s;
    end
    band = (((m * 6 / 1000) & MASK) * p) & MASK;
    e_au = ((aa < MASK - band) ? aa : MASK - band) + band;
    e_al = ((aa > band) ? aa : band) - band;
    v = (c * p) & MASK;
    e_ru = pct(v, 60);
    e_rl = pct(v, 40);
    e_t = pct(aa / p, 166) + m_b;
    if (e_t > MASK) begin e_t = MASK; f_sat = 1; end
    if (pct(aa / p, 166) == MASK) f_sat = 1;
  endtask

  task automatic wait_done(string tag);
    int k = 0;
    while (!done && k < 2000) begin @(negedge clk); k++; end
    if (!done) check(tag, 0, 1);
  endtask

  task automatic pulse(int kind);
    @(negedge clk);
    start  = (kind == 0);
    up_evt = (kind == 1 || kind == 3);
    dn_evt = (kind == 2 || kind == 3);
    @(negedge clk);
    start = 0; up_evt = 0; dn_evt = 0;
  endtask

  task automatic cmp_all(int kind);
    string tb;
    tb = (kind == 0) ? "R10" : (kind == 3) ? "R5" : f_clamp ? "R2" : f_floor ? "R4" :
         (kind == 1) ? "R1" : "R3";
    check(tb, boost, m_b);
    check(tb, ue, m_ue);
    check(tb, de, m_de);
    check(f_sat ? "R6" : "R9", target, e_t);
    check("R8", ru, e_ru);
    check("R8", rl, e_rl);
    check("R7", au, e_au);
    check("R7", al, e_al);
  endtask

  typedef struct packed {
    logic [1:0]  kind;
    logic [31:0] a, c, m;
    logic [8:0]  p;
  } vec_t;
  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 32'd0,          32'd400000, 32'd800000, 9'd12},
    '{2'd1, 32'd5000000,    32'd400000, 32'd800000, 9'd12},
    '{2'd1, 32'd6000000,    32'd400000, 32'd800000, 9'd12},
    '{2'd1, 32'd7000000,    32'd500000, 32'd800000, 9'd12},
    '{2'd1, 32'd7200000,    32'd600000, 32'd800000, 9'd12},
    '{2'd1, 32'd7500000,    32'd700000, 32'd800000, 9'd12},
    '{2'd1, 32'd9000000,    32'd800000, 32'd800000, 9'd12},
    '{2'd2, 32'd3000000,    32'd800000, 32'd800000, 9'd12},
    '{2'd2, 32'd2000000,    32'd600000, 32'd800000, 9'd12},
    '{2'd2, 32'd100,        32'd400000, 32'd800000, 9'd12},
    '{2'd2, 32'd900000,     32'd300000, 32'd800000, 9'd8},
    '{2'd2, 32'd800000,     32'd200000, 32'd800000, 9'd8},
    '{2'd2, 32'd700000,     32'd200000, 32'd800000, 9'd8},
    '{2'd2, 32'd600000,     32'd200000, 32'd800000, 9'd8},
    '{2'd1, 32'hFFFF_FFF0,  32'd200000, 32'd800000, 9'd1},
    '{2'd3, 32'd4000000,    32'd400000, 32'd900000, 9'd256},
    '{2'd0, 32'd0,          32'd300000, 32'd900000, 9'd20},
    '{2'd2, 32'd1000,       32'd300000, 32'd900000, 9'd20}
  };

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog got=%0d exp=%0d", cyc, 150000);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R13 reset state
    check("R13", boost, 0); check("R13", ue, 1); check("R13", de, 0);
    check("R13", busy, 0); check("R13", target, 0); check("R13", au, 0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      avg = VECS[i].a; cur = VECS[i].c; mx = VECS[i].m; per = VECS[i].p;
      pulse(int'(VECS[i].kind));
      wait_done("R12");
      model(int'(VECS[i].kind), VECS[i].a, VECS[i].c, VECS[i].m, VECS[i].p);
      cmp_all(int'(VECS[i].kind));
      @(negedge clk);
      check("R12", done, 0);
      check("R12", busy, 0);
    end

    // R5: the low half of a simultaneous pair is dropped
    begin
      int extra = 0;
      logic [31:0] b0;
      avg = 32'd2000000; cur = 32'd400000; mx = 32'd900000; per = 9'd12;
      pulse(3);
      wait_done("R5");
      model(3, 2000000, 400000, 900000, 12);
      cmp_all(3);
      b0 = boost;
      for (int k = 0; k < 600; k++) begin @(negedge clk); if (done || busy) extra++; end
      check("R5", extra, 0);
      check("R5", boost, b0);
    end

    // R11: a low event during an update is held and serviced afterwards
    avg = 32'd3000000;
    pulse(1);
    repeat (20) @(negedge clk);
    check("R11", busy, 1);
    @(negedge clk); dn_evt = 1; @(negedge clk); dn_evt = 0;
    wait_done("R11");
    model(1, 3000000, 400000, 900000, 12);
    check("R11", boost, m_b);
    @(negedge clk);
    wait_done("R11");
    model(2, 3000000, 400000, 900000, 12);
    check("R11", boost, m_b);
    check("R11", target, e_t);

    // R10: start discards a pending event and re-seeds
    @(negedge clk);
    start = 1; dn_evt = 1; @(negedge clk); start = 0; dn_evt = 0;
    wait_done("R10");
    model(0, 0, 400000, 900000, 12);
    cmp_all(0);
    begin
      int extra = 0;
      for (int k = 0; k < 600; k++) begin @(negedge clk); if (done) extra++; end
      check("R10", extra, 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule